// File: doc/BRIEF.md
# SPI Serial Flash Read Responder

This block is the device side of a serial flash that answers one command: the standard byte read. A host drives chip enable, serial clock and serial data in. It shifts in an 8-bit opcode and then a 24-bit address. The block then streams bytes from an internal byte array on serial data out. The stream has no length. The byte pointer steps up once per byte and returns to zero after the last location. The transfer ends only when chip enable goes high.

The block runs from one fast system clock. The three SPI inputs pass through two-flop synchronizers, and the block finds serial-clock edges by comparing successive synchronized samples. Serial data in is sampled on rising SCK. Serial data out changes on falling SCK. This order suits both clock polarities in which the idle level of SCK matches its phase (mode 0 and mode 3).

The array is inferred block RAM with a registered read port. A simple write port preloads it. Serial data out comes with a separate enable, and the pad is tri-stated whenever that enable is low.

Top module: `spi_flash_rd`

## Requirements
- R1: After chip enable falls, the first 8 bits sampled on rising SCK form the opcode, most significant bit first. The value 0x03 starts a read.
- R2: The 24 bits that follow are the start address, A23 first. Only the low ADDR_W bits select the byte, so the address is taken modulo the array size.
- R3: The first data bit is the most significant bit of the byte at the start address. It appears on serial data out after the falling SCK edge that follows the 32nd rising edge. Each later bit appears after the next falling edge, so each byte goes out MSB first, and serial data out does not change on a rising edge.
- R4: While chip enable stays low, bytes follow without a break, and each byte comes from the location one above the previous one.
- R5: After the byte at location 2^ADDR_W-1, the next byte comes from location 0.
- R6: The output enable is low from reset, through the opcode and address phases, and while chip enable is high. It goes high from the first data bit on.
- R7: If the opcode is not 0x03, the output enable stays low and all SCK activity is ignored until chip enable rises. A read issued after that works normally.
- R8: When chip enable rises at any point, including inside a byte or inside the address phase, the transfer aborts. The next chip enable fall starts again at the opcode phase.
- R9: Reads give identical data whether SCK idles low (mode 0) or high (mode 3) while chip enable is high.
- R10: While synchronous reset is high, the output enable and serial data out are both low.
- R11: A byte written on the load port at a location is the one later read from that location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe for the byte array |
| ld_addr | input | ADDR_W | Load-port byte location |
| ld_data | input | 8 | Load-port byte value |
| spi_cs_n | input | 1 | Chip enable, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host, registered |
| spi_so_oe | output | 1 | High when spi_so should drive the pad |

## Verification
Each SPI pin change reaches the control logic through two synchronizer flops. The output register then updates on the next clock, so spi_so and spi_so_oe settle about two and a half system clocks after the SCK or chip enable edge that causes them. The bench changes pins half a clock away from the active edge and holds each SCK level for four system clocks. It samples serial data out just before it raises SCK, and it checks the output enable after waiting past that latency. A load-port write is visible to a read one clock later, and the bench finishes every preload long before the first read.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam int         CMD_BITS  = 8;
  localparam int         ADDR_BITS = 24;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // One write port and one registered read port, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              si_s,
  input  logic [7:0]        mem_q,
  output logic [ADDR_W-1:0] ptr,
  output logic              so,
  output logic              so_oe
);
  localparam int CNT_W = $clog2(ADDR_BITS);

  phase_t            phase;
  logic              sck_d;
  logic [CNT_W-1:0]  cnt;
  logic [6:0]        cmd_sh;
  logic [ADDR_W-2:0] addr_sh;
  logic [2:0]        bitc;
  logic [6:0]        dout;

  logic              rise, fall;
  logic [7:0]        cmd_next;
  logic [ADDR_W-1:0] addr_next;

  assign rise      = sck_s & ~sck_d;
  assign fall      = ~sck_s & sck_d;
  assign cmd_next  = {cmd_sh, si_s};
  assign addr_next = {addr_sh, si_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_CMD;
      sck_d   <= sck_s;
      cnt     <= '0;
      cmd_sh  <= '0;
      addr_sh <= '0;
      ptr     <= '0;
      bitc    <= '0;
      dout    <= '0;
      so      <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (cs_s) begin
        // Chip enable high: abort whatever is in progress
        phase <= PH_CMD;
        cnt   <= '0;
        bitc  <= '0;
        so    <= 1'b0;
        so_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_CMD: if (rise) begin
            cmd_sh <= cmd_next[6:0];
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(CMD_BITS - 1)) begin
              cnt   <= '0;
              phase <= (cmd_next == OP_READ) ? PH_ADDR : PH_SKIP;
            end
          end
          PH_ADDR: if (rise) begin
            addr_sh <= addr_next[ADDR_W-2:0];
            cnt     <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_BITS - 1)) begin
              cnt   <= '0;
              ptr   <= addr_next;
              bitc  <= '0;
              phase <= PH_DATA;
            end
          end
          PH_DATA: if (fall) begin
            so_oe <= 1'b1;
            bitc  <= bitc + 1'b1;
            if (bitc == 3'd0) begin
              so   <= mem_q[7];
              dout <= mem_q[6:0];
              ptr  <= ptr + 1'b1;
            end else begin
              so   <= dout[6];
              dout <= {dout[5:0], 1'b0};
            end
          end
          PH_SKIP: ;
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  AST_OE_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> (phase == PH_DATA)); // R6
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !so_oe); // R8
  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP && !cs_s) |=> (phase == PH_SKIP && !so_oe)); // R7
  AST_SO_HOLD_RISE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && rise && !cs_s) |=> $stable(so)); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && fall && !cs_s && bitc == 3'd0)
      |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R5
  AST_ADDR_DONE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR && rise && !cs_s && cnt == CNT_W'(ADDR_BITS - 1))
      |=> (phase == PH_DATA)); // R2
endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe
);
  logic              cs_s, sck_s, si_s;
  logic [ADDR_W-1:0] rd_ptr;
  logic [7:0]        rd_data;

  spi_rd_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d(spi_cs_n), .q(cs_s));
  spi_rd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst(rst), .d(spi_sck), .q(sck_s));
  spi_rd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_si (
    .clk(clk), .rst(rst), .d(spi_si), .q(si_s));

  spi_rd_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  spi_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .cs_s  (cs_s),
    .sck_s (sck_s),
    .si_s  (si_s),
    .mem_q (rd_data),
    .ptr   (rd_ptr),
    .so    (spi_so),
    .so_oe (spi_so_oe)
  );
endmodule

// File: tb/spi_flash_rd_tb.sv
module spi_flash_rd_tb;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 4;
  localparam int NVEC  = 5;

  // {mode (1 = SCK idles high), start address[23:0], byte count[3:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 24'h000010, 4'd4},   // R1 R3 R4 basic read
    {1'b1, 24'h0000FD, 4'd6},   // R5 R9 wrap in mode 3
    {1'b0, 24'hABCD05, 4'd3},   // R2 upper address bits ignored
    {1'b1, 24'h7FFFFF, 4'd2},   // R2 R5 top location then zero
    {1'b0, 24'h000000, 4'd3}    // R4 from location zero
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic spi_cs_n = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_si = 1'b0;
  logic spi_so, spi_so_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  logic cur_mode;
  logic so_bit, oe_bit;

  always #2 clk = ~clk;

  spi_flash_rd #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_si(spi_si),
    .spi_so(spi_so), .spi_so_oe(spi_so_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    model[a] = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic cs_start(input logic mode);
    @(negedge clk);
    cur_mode = mode;
    spi_sck = mode;
    wait_clk(HALF);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  // One SCK period: fall, present data, sample SO, rise
  task automatic spi_bit(input logic b);
    spi_sck = 1'b0;
    spi_si = b;
    wait_clk(HALF);
    so_bit = spi_so;
    oe_bit = spi_so_oe;
    spi_sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    if (!cur_mode) begin
      spi_sck = 1'b0;
      wait_clk(HALF);
    end
    spi_cs_n = 1'b1;
    wait_clk(HALF + 2);
  endtask

  // Returns 1 if the output enable was seen high during the 32 header bits
  task automatic send_header(input logic [7:0] op, input logic [23:0] addr,
                             output logic oe_seen);
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(op[i]);
      oe_seen |= oe_bit;
    end
    for (int i = 23; i >= 0; i--) begin
      spi_bit(addr[i]);
      oe_seen |= oe_bit;
    end
  endtask

  task automatic get_byte(output logic [7:0] b, output logic oe_all);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(1'b0);
      b[i] = so_bit;
      oe_all &= oe_bit;
    end
  endtask

  task automatic do_read(input logic mode, input logic [23:0] addr, input int n,
                         input string req);
    logic oe_seen, oe_all;
    logic [7:0] got;
    logic [AW-1:0] a;
    cs_start(mode);
    send_header(8'h03, addr, oe_seen);
    chk("R6 oe low in header", {31'd0, oe_seen}, 32'd0);
    a = addr[AW-1:0];
    for (int k = 0; k < n; k++) begin
      get_byte(got, oe_all);
      chk(req, {24'd0, got}, {24'd0, model[a]});
      chk("R6 oe high in data", {31'd0, oe_all}, 32'd1);
      a = a + 1'b1;
    end
    cs_end();
    chk("R6 oe low after cs", {31'd0, spi_so_oe}, 32'd0);
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R1 R3 R4 stream";
      1: return "R5 R9 mode3 wrap";
      2: return "R2 modulo address";
      3: return "R5 top then zero";
      default: return "R4 stream";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic oe_seen, oe_all;
    logic [7:0] got;
    cur_mode = 1'b0;
    wait_clk(3);
    chk("R10 oe in reset", {31'd0, spi_so_oe}, 32'd0);
    chk("R10 so in reset", {31'd0, spi_so}, 32'd0);
    rst = 1'b0;
    wait_clk(2);
    for (int i = 0; i < DEPTH; i++) load(AW'(i), 8'(i * 37 + 11));
    wait_clk(4);

    // Table of reads, expected data from the model array
    for (int v = 0; v < NVEC; v++)
      do_read(VEC[v][28], VEC[v][27:4], int'(VEC[v][3:0]), vec_tag(v));

    // R11: overwrite a location and read it back
    load(8'h33, 8'hA5);
    load(8'h34, 8'h5A);
    do_read(1'b0, 24'h000033, 2, "R11 loaded byte");

    // R7: unknown opcode, SCK keeps running, SO never enabled
    cs_start(1'b0);
    send_header(8'h0B, 24'h000010, oe_seen);
    for (int i = 0; i < 16; i++) begin
      spi_bit(1'b1);
      oe_seen |= oe_bit;
    end
    chk("R7 oe after bad opcode", {31'd0, oe_seen}, 32'd0);
    cs_end();
    do_read(1'b1, 24'h000020, 2, "R7 read after bad opcode");

    // R8: abort in the middle of the second byte
    cs_start(1'b0);
    send_header(8'h03, 24'h000040, oe_seen);
    get_byte(got, oe_all);
    chk("R8 byte before abort", {24'd0, got}, {24'd0, model[8'h40]});
    for (int i = 0; i < 4; i++) spi_bit(1'b0);
    cs_end();
    chk("R8 oe after abort", {31'd0, spi_so_oe}, 32'd0);
    do_read(1'b0, 24'h000055, 2, "R8 read after data abort");

    // R8: abort during the address phase
    cs_start(1'b1);
    for (int i = 7; i >= 0; i--) spi_bit(((8'h03 >> i) & 8'h01) != 0);
    for (int i = 0; i < 10; i++) spi_bit(1'b1);
    cs_end();
    do_read(1'b1, 24'h000080, 2, "R8 read after address abort");

    // R10: reset in the middle of a stream
    cs_start(1'b0);
    send_header(8'h03, 24'h000001, oe_seen);
    get_byte(got, oe_all);
    @(negedge clk);
    rst = 1'b1;
    wait_clk(2);
    chk("R10 oe during reset", {31'd0, spi_so_oe}, 32'd0);
    chk("R10 so during reset", {31'd0, spi_so}, 32'd0);
    rst = 1'b0;
    cs_end();
    do_read(1'b0, 24'h0000FF, 2, "R10 R5 read after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule